// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block plays the target side of a parallel SCSI bus. It watches the initiator's SEL, ATN, BSY, ACK and data lines. It answers a selection addressed to a device that is present and then steps through the bus phases: an optional message-out phase, the command phase, a data phase in either direction, status, message in, and finally bus free. Every byte moves by a REQ/ACK handshake. The byte is taken on the rising edge of ACK, and REQ comes back after a fixed countdown.

On the device side there is a simple byte buffer and a few control lines. Command bytes are written to the low buffer slots, and a one-cycle strobe marks the end of the command. The device answers with a next-phase code, a transfer length and a status byte. Data-out bytes are written into the buffer and data-in bytes are read from it, both starting above the command slots. The block does not generate parity, time arbitration, disconnect or execute commands.

Top module: `scsi_tgt_seq`

## Requirements
- R1: When idle, a selection is taken when sel_i is high and bsy_i is low. The target is the lowest-numbered set bit of data_i. If that device is present, bsy_o rises on the next edge and target_id_o holds the number.
- R2: If no data bit is set, or the lowest set bit names an absent device, bsy_o stays low and the block stays idle.
- R3: When SEL drops after a selection, the next step depends on ATN. With ATN low, the command phase starts with REQ high on the first edge. With ATN high, the message-out phase starts with REQ high 4 edges later.
- R4: A byte is captured only on a rising ACK while REQ is high, and REQ falls on that same edge. Command byte n is written to buffer address n. Data-out byte n is written to address CDB_SLOTS+n.
- R5: The command length is set by bits 7:5 of the first byte. Groups 0 to 7 give 6, 10, 10, 6, 16, 12, 10 and 6 bytes. cmd_done_o pulses for one cycle when the last byte is captured.
- R6: After a byte that does not end its phase, REQ returns 3 edges after the capture edge.
- R7: A phase change takes place 4 edges after the capture that causes it. On entry to status or message in, REQ rises 8 edges after that capture. This also holds for status that follows the command phase directly.
- R8: The message-out length is decoded from the first byte. 0x00, 0x02 to 0x1F, and 0x80 and above take 1 byte. 0x20 to 0x2F take 2 bytes. Any other value is extended: 3 bytes are assumed until the second byte arrives, and that byte then gives the total length. After the final byte, command-phase REQ rises one edge after the capture.
- R9: A first message byte with bit 7 set and bit 5 clear loads its bits 2:0 into lun_o. Any other message leaves lun_o unchanged.
- R10: In data in, byte n comes from buffer address CDB_SLOTS+n. The data phase ends after xfer_len_i bytes and status follows. A data phase code with zero length, or any code that is not a data phase, leads straight to status.
- R11: The status phase presents status_i. Message in presents 0x00. BSY is released 4 edges after the message-in ACK.
- R12: The phase appears on {msg_o, cd_o, io_o} as follows: data out 000, data in 001, command 010, status 011, message out 110, message in 111.
- R13: A synchronous rst returns the block to idle. It drops BSY and REQ, zeroes the phase and data lines, and clears all counters, positions and the latched LUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | SEL from the initiator |
| atn_i | input | 1 | ATN from the initiator |
| bsy_i | input | 1 | BSY as driven by other bus devices |
| ack_i | input | 1 | ACK from the initiator |
| data_i | input | 8 | Bus data as driven by the initiator |
| bsy_o | output | 1 | Target BSY |
| req_o | output | 1 | Target REQ |
| cd_o | output | 1 | Command/data phase bit |
| io_o | output | 1 | Direction phase bit (1 = to initiator) |
| msg_o | output | 1 | Message phase bit |
| data_o | output | 8 | Byte driven by the target in inbound phases |
| dev_present_i | input | NUM_IDS | One bit per bus ID that has a device |
| target_id_o | output | ID_W | ID chosen at selection |
| lun_o | output | 3 | Logical unit from the identify message |
| cmd_done_o | output | 1 | One-cycle strobe when the command is complete |
| next_phase_i | input | 3 | Device phase code after the command |
| xfer_len_i | input | LEN_W | Data phase length in bytes |
| status_i | input | 8 | Status byte |
| buf_raddr_o | output | ADDR_W | Buffer read address |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the address |
| buf_we_o | output | 1 | Buffer write enable |
| buf_waddr_o | output | ADDR_W | Buffer write address |
| buf_wdata_o | output | 8 | Buffer write data |

## Verification
A wrong state or an off-by-one position shows at the ports within one handshake. If REQ comes back at the wrong edge, the initiator's REQ-return count is wrong. If the phase bits are wrong, the byte seen at the next REQ is wrong. If a length decode is wrong, the command or message phase ends one byte early or late. The cmd_done count, the buffer contents and the lun output make such an error visible at once. A wrong bus-free decision leaves BSY high, or drops it, at a known edge after the message-in ACK.

// File: rtl/scsi_tgt_pkg.sv
`timescale 1ns/1ps
package scsi_tgt_pkg;

  // bus phase code on {MSG, C/D, I/O}
  typedef enum logic [2:0] {
    PH_DOUT = 3'b000,
    PH_DIN  = 3'b001,
    PH_CMD  = 3'b010,
    PH_STAT = 3'b011,
    PH_MOUT = 3'b110,
    PH_MIN  = 3'b111
  } phase_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_WAIT, ST_MOUT, ST_MID,
    ST_CMD, ST_DIN, ST_DOUT, ST_STAT, ST_MIN
  } seq_e;

  // command block size from the opcode group
  function automatic logic [4:0] cdb_bytes(input logic [2:0] grp);
    case (grp)
      3'd0, 3'd3, 3'd7: return 5'd6;
      3'd1, 3'd2, 3'd6: return 5'd10;
      3'd4:             return 5'd16;
      default:          return 5'd12;
    endcase
  endfunction

  // message length guess from the leading byte; 3 marks an extended message
  function automatic logic [7:0] msg_first_len(input logic [7:0] b);
    if (b == 8'h00 || b >= 8'h80 || (b >= 8'h02 && b <= 8'h1F)) return 8'd1;
    if (b >= 8'h20 && b <= 8'h2F) return 8'd2;
    return 8'd3;
  endfunction

endpackage

// File: rtl/tgt_id_pick.sv
`timescale 1ns/1ps
module tgt_id_pick #(
  parameter int NUM_IDS = 8,
  parameter int ID_W    = $clog2(NUM_IDS)
) (
  input  logic [NUM_IDS-1:0] sel_bits,
  input  logic [NUM_IDS-1:0] present,
  output logic               hit,
  output logic [ID_W-1:0]    id
);
  logic any;

  // scan from the top so the lowest set bit wins
  always_comb begin
    any = 1'b0;
    id  = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (sel_bits[i]) begin
        any = 1'b1;
        id  = ID_W'(i);
      end
    end
  end

  assign hit = any && present[id];
endmodule

// File: rtl/tgt_delay.sv
`timescale 1ns/1ps
module tgt_delay #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // an action loaded with N happens N edges after the load edge
  assign fire = (cnt == CNT_W'(1));

  a_r7_counts_down: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !load) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/scsi_tgt_seq.sv
`timescale 1ns/1ps
module scsi_tgt_seq
  import scsi_tgt_pkg::*;
#(
  parameter int NUM_IDS      = 8,
  parameter int ID_W         = $clog2(NUM_IDS),
  parameter int ADDR_W       = 8,
  parameter int LEN_W        = ADDR_W,
  parameter int CDB_SLOTS    = 16,
  parameter int PH_DLY       = 4,
  parameter int STAT_REQ_DLY = 8,
  parameter int BYTE_REQ_DLY = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_i,
  input  logic               atn_i,
  input  logic               bsy_i,
  input  logic               ack_i,
  input  logic [7:0]         data_i,
  output logic               bsy_o,
  output logic               req_o,
  output logic               cd_o,
  output logic               io_o,
  output logic               msg_o,
  output logic [7:0]         data_o,
  input  logic [NUM_IDS-1:0] dev_present_i,
  output logic [ID_W-1:0]    target_id_o,
  output logic [2:0]         lun_o,
  output logic               cmd_done_o,
  input  logic [2:0]         next_phase_i,
  input  logic [LEN_W-1:0]   xfer_len_i,
  input  logic [7:0]         status_i,
  output logic [ADDR_W-1:0]  buf_raddr_o,
  input  logic [7:0]         buf_rdata_i,
  output logic               buf_we_o,
  output logic [ADDR_W-1:0]  buf_waddr_o,
  output logic [7:0]         buf_wdata_o
);
  localparam int CNT_W = $clog2(STAT_REQ_DLY + 1);
  localparam logic [CNT_W-1:0] PH_V   = CNT_W'(PH_DLY);
  localparam logic [CNT_W-1:0] STAT_V = CNT_W'(STAT_REQ_DLY);
  localparam logic [CNT_W-1:0] BYTE_V = CNT_W'(BYTE_REQ_DLY);
  localparam logic [CNT_W-1:0] REST_V = CNT_W'(STAT_REQ_DLY - PH_DLY);
  localparam logic [ADDR_W-1:0] DATA_BASE = ADDR_W'(CDB_SLOTS);

  seq_e              state, pend_st;
  logic              pend_dev;
  phase_e            phase_q;
  logic              ack_q;
  logic [ADDR_W-1:0] pos;
  logic [4:0]        cdb_len;
  logic [7:0]        msg_cnt, msg_len;
  logic              msg_ext;
  logic [LEN_W-1:0]  xfer_len_q;

  logic              id_hit;
  logic [ID_W-1:0]   id_sel;
  logic              ph_load, rq_load, ph_fire, rq_fire;
  logic [CNT_W-1:0]  rq_val;

  tgt_id_pick #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_pick (
    .sel_bits (data_i[NUM_IDS-1:0]),
    .present  (dev_present_i),
    .hit      (id_hit),
    .id       (id_sel)
  );

  tgt_delay #(.CNT_W(CNT_W)) u_ph_dly (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(PH_V), .fire(ph_fire)
  );

  tgt_delay #(.CNT_W(CNT_W)) u_rq_dly (
    .clk(clk), .rst(rst), .load(rq_load), .load_val(rq_val), .fire(rq_fire)
  );

  // handshake and length decisions
  logic       ack_rise, last_cmd, last_data, msg_done, dev_stat;
  logic [4:0] cdb_eff;
  logic [7:0] msg_tot;

  assign ack_rise  = ack_i && !ack_q && req_o;
  assign cdb_eff   = (pos == '0) ? cdb_bytes(data_i[7:5]) : cdb_len;
  assign last_cmd  = (32'(pos) + 1 == 32'(cdb_eff));
  assign last_data = (32'(pos) + 1 >= 32'(xfer_len_q));
  assign msg_tot   = (msg_cnt == 8'd0) ? msg_first_len(data_i) :
                     (msg_cnt == 8'd1 && msg_ext) ? data_i : msg_len;
  assign msg_done  = (32'(msg_cnt) + 1 >= 32'(msg_tot));
  assign dev_stat  = !(((next_phase_i == PH_DIN) || (next_phase_i == PH_DOUT))
                       && (xfer_len_i != '0));

  always_comb begin
    ph_load = 1'b0;
    rq_load = 1'b0;
    rq_val  = BYTE_V;
    case (state)
      ST_SEL:  ph_load = !sel_i && atn_i;
      ST_CMD:  if (ack_rise) begin
                 if (last_cmd) ph_load = 1'b1;
                 else          rq_load = 1'b1;
               end
      ST_DIN, ST_DOUT:
               if (ack_rise) begin
                 rq_load = 1'b1;
                 if (last_data) begin
                   ph_load = 1'b1;
                   rq_val  = STAT_V;
                 end
               end
      ST_STAT: if (ack_rise) begin
                 ph_load = 1'b1;
                 rq_load = 1'b1;
                 rq_val  = STAT_V;
               end
      ST_MIN:  ph_load = ack_rise;
      ST_MOUT: rq_load = ack_rise && !msg_done;
      ST_WAIT: if (ph_fire && pend_dev && dev_stat) begin
                 rq_load = 1'b1;
                 rq_val  = REST_V;
               end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pend_st     <= ST_IDLE;
      pend_dev    <= 1'b0;
      phase_q     <= PH_DOUT;
      ack_q       <= 1'b0;
      pos         <= '0;
      cdb_len     <= '0;
      msg_cnt     <= '0;
      msg_len     <= '0;
      msg_ext     <= 1'b0;
      xfer_len_q  <= '0;
      bsy_o       <= 1'b0;
      req_o       <= 1'b0;
      data_o      <= '0;
      target_id_o <= '0;
      lun_o       <= '0;
      cmd_done_o  <= 1'b0;
      buf_we_o    <= 1'b0;
      buf_waddr_o <= '0;
      buf_wdata_o <= '0;
    end else begin
      ack_q      <= ack_i;
      cmd_done_o <= 1'b0;
      buf_we_o   <= 1'b0;
      if (rq_fire) begin
        req_o <= 1'b1;
        if (state == ST_DIN) data_o <= buf_rdata_i;
      end
      case (state)
        ST_IDLE: if (sel_i && !bsy_i && id_hit) begin
          bsy_o       <= 1'b1;
          target_id_o <= id_sel;
          state       <= ST_SEL;
        end
        ST_SEL: if (!sel_i) begin
          if (!atn_i) begin
            state   <= ST_CMD;
            phase_q <= PH_CMD;
            req_o   <= 1'b1;
            pos     <= '0;
          end else begin
            state    <= ST_WAIT;
            pend_st  <= ST_MOUT;
            pend_dev <= 1'b0;
            msg_cnt  <= '0;
            msg_ext  <= 1'b0;
          end
        end
        ST_WAIT: if (ph_fire) begin
          if (pend_dev) begin
            if (dev_stat) begin
              state   <= ST_STAT;
              phase_q <= PH_STAT;
              data_o  <= status_i;
            end else begin
              xfer_len_q <= xfer_len_i;
              req_o      <= 1'b1;
              if (next_phase_i == PH_DIN) begin
                state   <= ST_DIN;
                phase_q <= PH_DIN;
                data_o  <= buf_rdata_i;
              end else begin
                state   <= ST_DOUT;
                phase_q <= PH_DOUT;
              end
            end
          end else begin
            case (pend_st)
              ST_MOUT: begin
                state   <= ST_MOUT;
                phase_q <= PH_MOUT;
                req_o   <= 1'b1;
              end
              ST_STAT: begin
                state   <= ST_STAT;
                phase_q <= PH_STAT;
                data_o  <= status_i;
              end
              ST_MIN: begin
                state   <= ST_MIN;
                phase_q <= PH_MIN;
                data_o  <= 8'h00;
              end
              default: begin
                state   <= ST_IDLE;
                phase_q <= PH_DOUT;
                bsy_o   <= 1'b0;
                data_o  <= 8'h00;
              end
            endcase
          end
        end
        ST_MOUT: if (ack_rise) begin
          req_o   <= 1'b0;
          msg_cnt <= msg_cnt + 8'd1;
          if (msg_cnt == 8'd0) begin
            msg_len <= msg_first_len(data_i);
            msg_ext <= (msg_first_len(data_i) == 8'd3);
            if (data_i[7] && !data_i[5]) lun_o <= data_i[2:0];
          end else if (msg_cnt == 8'd1 && msg_ext) begin
            msg_len <= data_i;
          end
          if (msg_done) state <= ST_MID;
        end
        ST_MID: begin
          state   <= ST_CMD;
          phase_q <= PH_CMD;
          req_o   <= 1'b1;
          pos     <= '0;
        end
        ST_CMD: if (ack_rise) begin
          req_o       <= 1'b0;
          buf_we_o    <= 1'b1;
          buf_waddr_o <= pos;
          buf_wdata_o <= data_i;
          if (pos == '0) cdb_len <= cdb_bytes(data_i[7:5]);
          if (last_cmd) begin
            cmd_done_o <= 1'b1;
            pos        <= '0;
            pend_dev   <= 1'b1;
            state      <= ST_WAIT;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        ST_DIN, ST_DOUT: if (ack_rise) begin
          req_o <= 1'b0;
          pos   <= pos + 1'b1;
          if (state == ST_DOUT) begin
            buf_we_o    <= 1'b1;
            buf_waddr_o <= DATA_BASE + pos;
            buf_wdata_o <= data_i;
          end
          if (last_data) begin
            state    <= ST_WAIT;
            pend_st  <= ST_STAT;
            pend_dev <= 1'b0;
          end
        end
        ST_STAT: if (ack_rise) begin
          req_o    <= 1'b0;
          state    <= ST_WAIT;
          pend_st  <= ST_MIN;
          pend_dev <= 1'b0;
        end
        ST_MIN: if (ack_rise) begin
          req_o    <= 1'b0;
          state    <= ST_WAIT;
          pend_st  <= ST_IDLE;
          pend_dev <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign {msg_o, cd_o, io_o} = phase_q;
  assign buf_raddr_o = DATA_BASE + pos;

  // R1: the target never requests without holding the bus
  a_r1_req_only_with_bsy: assert property (@(posedge clk) disable iff (rst)
    req_o |-> bsy_o);

  // R4: a captured byte always takes REQ down
  a_r4_req_drops_on_ack: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !ack_q && req_o) |=> !req_o);

  // R4: buffer writes only come from the command or data-out phase
  a_r4_write_source: assert property (@(posedge clk) disable iff (rst)
    buf_we_o |-> ($past(state) == ST_CMD || $past(state) == ST_DOUT));

  // R5: completion is a single-cycle strobe
  a_r5_done_is_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_done_o |=> !cmd_done_o);

  // R9: the unit number only moves during message out
  a_r9_lun_from_msgout: assert property (@(posedge clk) disable iff (rst)
    !$stable(lun_o) |-> ($past(state) == ST_MOUT));

  // R11: the bus is released only out of message in
  a_r11_free_after_msgin: assert property (@(posedge clk) disable iff (rst)
    $fell(bsy_o) |-> ($past(phase_q) == PH_MIN));

  // R12: phase lines hold still while a request is outstanding
  a_r12_phase_stable_in_req: assert property (@(posedge clk) disable iff (rst)
    (req_o && $past(req_o)) |-> $stable({msg_o, cd_o, io_o}));
endmodule

// File: tb/test_scsi_tgt_seq.sv
`timescale 1ns/1ps
module test_scsi_tgt_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_i = 0, atn_i = 0, bsy_i = 0, ack_i = 0;
  logic [7:0] data_i = '0;
  logic bsy_o, req_o, cd_o, io_o, msg_o;
  logic [7:0] data_o;
  logic [7:0] dev_present = 8'b0010_1010;
  logic [2:0] target_id;
  logic [2:0] lun;
  logic cmd_done;
  logic [2:0] next_phase = 3'b001;
  logic [7:0] xfer_len = 8'd0;
  logic [7:0] status = 8'h00;
  logic [7:0] raddr, waddr, wdata, rdata;
  logic we;

  always #4 clk = ~clk;

  scsi_tgt_seq i_scsi_tgt_seq (
    .clk(clk), .rst(rst), .sel_i(sel_i), .atn_i(atn_i), .bsy_i(bsy_i),
    .ack_i(ack_i), .data_i(data_i), .bsy_o(bsy_o), .req_o(req_o),
    .cd_o(cd_o), .io_o(io_o), .msg_o(msg_o), .data_o(data_o),
    .dev_present_i(dev_present), .target_id_o(target_id), .lun_o(lun),
    .cmd_done_o(cmd_done), .next_phase_i(next_phase), .xfer_len_i(xfer_len),
    .status_i(status), .buf_raddr_o(raddr), .buf_rdata_i(rdata),
    .buf_we_o(we), .buf_waddr_o(waddr), .buf_wdata_o(wdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 90);
  endfunction

  // device-side buffer model
  logic [7:0] mem [0:255];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= pat(int'(raddr));
  end

  int n_chk = 0, n_err = 0, n_done = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(negedge clk) if (!rst && cmd_done) n_done++;

  // scoreboard: expected {phase, byte} for every inbound request
  logic [10:0] exp_q[$];
  logic req_prev = 0;
  task automatic push_exp(input logic [2:0] ph, input logic [7:0] d);
    exp_q.push_back({ph, d});
  endtask

  always @(negedge clk) begin
    if (rst) req_prev = 0;
    else begin
      if (req_o && !req_prev && io_o) begin
        if (exp_q.size() == 0) check("R10/R11 unexpected inbound byte", {msg_o, cd_o, io_o, data_o}, 0);
        else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          check("R10/R11/R12 inbound phase+byte", {msg_o, cd_o, io_o, data_o}, e);
        end
      end
      req_prev = req_o;
    end
  end

  task automatic xfer(input logic [7:0] d, output int k);
    while (!req_o) @(negedge clk);
    data_i = d; ack_i = 1; k = 0;
    @(negedge clk); k = 1; ack_i = 0;
    while (!req_o && k < 20) begin @(negedge clk); k++; end
    if (!req_o) k = 0;
  endtask

  task automatic select(input logic [7:0] ids, input logic atn);
    data_i = ids; atn_i = atn; sel_i = 1;
    @(negedge clk);
  endtask

  task automatic release_sel(output int k);
    sel_i = 0; k = 0;
    do begin @(negedge clk); k++; end while (!req_o && k < 20);
    if (!req_o) k = 0;
  endtask

  task automatic send_cmd(input logic [7:0] b[], input int last_k, input string tag);
    int k;
    foreach (b[i]) begin
      xfer(b[i], k);
      if (i == 0) check("R6 REQ return after first command byte", k, 4);
      if (i == b.size() - 1) check(tag, k, last_k);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    int k, bad, done0;
    logic [7:0] cdb_a[] = '{8'h28, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00, 8'h05, 8'h00};
    logic [7:0] cdb_b[] = '{8'h0A, 8'h01, 8'h02, 8'h03, 8'h03, 8'h00};
    logic [7:0] cdb_c[] = '{8'hA0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11};
    logic [7:0] cdb_d[] = '{8'hC0, 1, 2, 3, 4, 5, 6, 7, 8, 9};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R13 reset bsy/req/phase/data", {bsy_o, req_o, msg_o, cd_o, io_o, data_o}, 0);

    // R2: empty and absent selections
    select(8'h00, 0); @(negedge clk);
    check("R2 no id bit leaves bus free", bsy_o, 0);
    sel_i = 0; @(negedge clk);
    select(8'h04, 0); @(negedge clk);
    check("R2 absent id leaves bus free", bsy_o, 0);
    sel_i = 0; @(negedge clk);

    // transaction A: read-style, data in 5 bytes
    next_phase = 3'b001; xfer_len = 8'd5; status = 8'h02;
    select(8'h28, 0);
    check("R1 bsy after selection", bsy_o, 1);
    check("R1 lowest set bit chosen", target_id, 3);
    release_sel(k);
    check("R3 command REQ on first edge with ATN low", k, 1);
    check("R12 command phase code", {msg_o, cd_o, io_o}, 3'b010);
    for (int i = 0; i < 5; i++) push_exp(3'b001, pat(16 + i));
    push_exp(3'b011, 8'h02);
    push_exp(3'b111, 8'h00);
    done0 = n_done;
    for (int i = 0; i < 9; i++) xfer(cdb_a[i], k);
    check("R5 no completion before tenth group-1 byte", n_done - done0, 0);
    xfer(cdb_a[9], k);
    check("R7 data phase REQ after last command byte", k, 5);
    check("R5 completion strobe count", n_done - done0, 1);
    bad = 0;
    for (int i = 0; i < 10; i++) if (mem[i] !== cdb_a[i]) bad++;
    check("R4 command bytes in buffer", bad, 0);
    check("R12 data in phase code", {msg_o, cd_o, io_o}, 3'b001);
    for (int i = 0; i < 5; i++) xfer(8'h00, k);
    check("R10/R7 status REQ 8 edges after last data byte", k, 9);
    xfer(8'h00, k);
    check("R7 message-in REQ after status", k, 9);
    xfer(8'h00, k);
    check("R11 no REQ after message in", k, 0);
    check("R11 bus free after message in", {bsy_o, msg_o, cd_o, io_o}, 0);

    // transaction B: extended message out, write-style 3 bytes
    next_phase = 3'b000; xfer_len = 8'd3; status = 8'h00;
    select(8'h20, 1);
    check("R1 id five selected", target_id, 5);
    release_sel(k);
    check("R3 message-out REQ 4 edges with ATN high", k, 5);
    check("R12 message out phase code", {msg_o, cd_o, io_o}, 3'b110);
    xfer(8'h01, k); check("R8 extended first byte continues", k, 4);
    xfer(8'h05, k); check("R8 length byte continues", k, 4);
    xfer(8'h11, k); check("R8 third byte continues by length byte", k, 4);
    xfer(8'h22, k);
    xfer(8'h33, k); check("R8 fifth byte ends message", k, 2);
    check("R12 command phase after message", {msg_o, cd_o, io_o}, 3'b010);
    check("R9 extended message leaves lun", lun, 0);
    push_exp(3'b011, 8'h00);
    push_exp(3'b111, 8'h00);
    send_cmd(cdb_b, 5, "R5 group-0 command is 6 bytes");
    check("R12 data out phase code", {msg_o, cd_o, io_o}, 3'b000);
    xfer(8'hA1, k); check("R6 data out REQ return", k, 4);
    xfer(8'hB2, k);
    xfer(8'hC3, k); check("R7 status REQ after data out", k, 9);
    check("R4 data out bytes in buffer", {mem[16], mem[17], mem[18]}, 24'hA1B2C3);
    xfer(8'h00, k);
    xfer(8'h00, k);
    check("R11 bus free after B", bsy_o, 0);

    // transaction C: identify, group 5, status straight after command
    next_phase = 3'b011; status = 8'h04;
    select(8'h08, 1);
    release_sel(k);
    xfer(8'hC3, k);
    check("R8 identify is one byte", k, 2);
    check("R9 lun from identify", lun, 3);
    push_exp(3'b011, 8'h04);
    push_exp(3'b111, 8'h00);
    send_cmd(cdb_c, 9, "R5/R7 group-5 12 bytes then status REQ at 8");
    xfer(8'h00, k);
    xfer(8'h00, k);
    check("R11 bus free after C", bsy_o, 0);

    // transaction D: two-byte message, zero-length data goes to status
    next_phase = 3'b001; xfer_len = 8'd0; status = 8'h08;
    select(8'h02, 1);
    check("R1 id one selected", target_id, 1);
    release_sel(k);
    xfer(8'h21, k); check("R8 two-byte message continues", k, 4);
    xfer(8'h07, k); check("R8 two-byte message ends", k, 2);
    check("R9 non-identify leaves lun", lun, 3);
    push_exp(3'b011, 8'h08);
    push_exp(3'b111, 8'h00);
    send_cmd(cdb_d, 9, "R10 zero length goes to status");
    xfer(8'h00, k);
    xfer(8'h00, k);
    check("R11 bus free after D", bsy_o, 0);

    // transaction E: reset in the middle of a command
    select(8'h28, 0);
    release_sel(k);
    xfer(8'h08, k);
    xfer(8'h00, k);
    rst = 1;
    @(negedge clk); @(negedge clk);
    check("R13 reset clears bus outputs", {bsy_o, req_o, msg_o, cd_o, io_o, data_o}, 0);
    check("R13 reset clears lun", lun, 0);
    rst = 0;
    @(negedge clk);
    check("R13 idle after reset", {bsy_o, req_o}, 0);
    check("R10/R11 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule